// File: doc/BRIEF.md
# Handshaked Serial Peripheral Port

An 8-bit serial peripheral port that sits behind a three-register bus. Software sets the operating mode through a control register. A write to the data register loads an 8-bit shift register. In master mode that write also starts a byte exchange, and the block generates the serial clock itself by dividing the system clock. In slave mode the block follows a clock and a select line driven by another device, and the loaded byte goes out as that device clocks it. In both modes the byte leaves most significant bit first, and the byte received at the same time becomes readable from the data register.

When a byte completes, a done flag is raised in the status register, and an interrupt can be raised from it. The flag is cleared by a fixed handshake: software first reads the status register while the flag is set, then accesses the data register. Until the status read has happened, writes to the data register are dropped, so a new byte can never overwrite an exchange that software has not yet acknowledged.

Top module: `spi_hsk`

## Requirements
- R1: A data-register write (offset 2) that is accepted loads the byte into the shift register. In master mode (control bit0 enable = 1, bit1 master = 1) the accepted write starts a transfer. The byte appears most significant bit first on `mosi_o` in master mode and on `miso_o` in slave mode.
- R2: The end of each byte sets the done flag, which is status register (offset 1) bit 7. The other status bits read 0.
- R3: `irq` is high exactly when the done flag is set, control bit4 (interrupt enable) is 1 and `irq_mask` is 0.
- R4: A status read while the flag is set arms the clear. The next data-register access then clears the flag: in master mode either a read or a write, in slave mode only a read. A data read that is not preceded by an arming status read leaves the flag set.
- R5: While the flag is set and no arming status read has occurred, data-register writes are ignored: no transfer starts and the flag stays set.
- R6: In master mode `sck_o` idles at control bit2 (clock polarity). During a transfer it makes 8 pulses, and each half period lasts DIV/2 system clocks.
- R7: With control bit3 (phase) = 0, data is sampled on the leading SCK edge and changed on the trailing edge. With phase = 1, data is changed on the leading edge and sampled on the trailing edge.
- R8: In master mode, bits are taken from `miso_i` most significant bit first. A data-register read after completion returns the received byte.
- R9: In slave mode (enable = 1, master = 0), shifting follows `sck_i` and `mosi_i` only while `ss_n_i` is low. After completion, a data-register read returns the byte received on `mosi_i`. With phase = 1, consecutive bytes may be exchanged with `ss_n_i` held low throughout.
- R10: In slave mode, if `ss_n_i` goes high before the eighth bit, the byte is abandoned: the done flag is not set, and the next byte is counted from its first bit.
- R11: The control register (offset 0) reads back the last byte written to it, and its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_mask | input | 1 | CPU-level interrupt mask |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock output (master) |
| mosi_o | output | 1 | Serial data output (master) |
| miso_i | input | 1 | Serial data input (master) |
| sck_i | input | 1 | Serial clock input (slave) |
| mosi_i | input | 1 | Serial data input (slave) |
| miso_o | output | 1 | Serial data output (slave) |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The bench builds the block with DIV = 8, which gives a master half period of 4 system clocks. At that length, a divider that is one cycle short or one cycle long shows up directly in the edge spacing that the bench measures. The bench drives the slave clock at a half period of 8 system clocks. That leaves room for the input synchronisers, and it lets the bench exercise every clock polarity and phase combination, an abort in the middle of a byte, and back-to-back bytes with select held low. The master input is tied to the inverse of the master output, so the received byte differs from the transmitted one and both paths are checked independently.

// File: rtl/spi_hsk_pkg.sv
package spi_hsk_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;

  typedef struct packed {
    logic [2:0] spare;
    logic       ie;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  // shift a new bit into the low end of a byte
  function automatic logic [7:0] push_bit(input logic [7:0] v, input logic b);
    return {v[6:0], b};
  endfunction

  // completion point: phase 0 ends after the eighth trailing edge
  // (8 samples taken), phase 1 on the trailing edge that takes sample 8
  function automatic logic last_edge(input logic cpha, input logic [3:0] cnt);
    return cpha ? (cnt == 4'd7) : (cnt == 4'd8);
  endfunction
endpackage

// File: rtl/spi_hsk_regs.sv
module spi_hsk_regs
  import spi_hsk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        xfer_done,
  input  logic [7:0]  rx_byte,
  input  logic        busy,
  output ctrl_t       ctrl,
  output logic [7:0]  rdata,
  output logic        load,
  output logic        flag,
  output logic        armed
);
  logic       stat_rd, data_rd, data_wr, clr;
  logic [7:0] rx_q;

  assign stat_rd = rd_en && (addr == OFS_STAT);
  assign data_rd = rd_en && (addr == OFS_DATA);
  assign data_wr = wr_en && (addr == OFS_DATA);
  assign clr     = armed && (data_rd || (ctrl.master && data_wr));
  assign load    = data_wr && ctrl.en && (!flag || armed) && !(ctrl.master && busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
      rx_q  <= '0;
    end else begin
      if (wr_en && addr == OFS_CTRL) ctrl <= ctrl_t'(wdata);
      if (xfer_done) rx_q <= rx_byte;
      if (xfer_done)  flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
      if (clr)                  armed <= 1'b0;
      else if (stat_rd && flag) armed <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = ctrl;
      OFS_STAT: rdata = {flag, 7'b0};
      OFS_DATA: rdata = rx_q;
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_hsk_clkgen.sv
module spi_hsk_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic lead,
  output logic trail,
  output logic phase
);
  localparam int HALF = (DIV / 2 > 0) ? DIV / 2 : 1;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] div_q;
  logic [3:0]    ecnt;
  logic          tick;

  assign tick  = busy && (div_q == CW'(HALF - 1));
  assign lead  = tick && !ecnt[0];
  assign trail = tick && ecnt[0];
  assign phase = ecnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      div_q <= '0;
      ecnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        div_q <= '0;
        ecnt  <= '0;
      end
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        ecnt <= ecnt + 1'b1;
        if (ecnt == 4'd15) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_hsk_shifter.sv
module spi_hsk_shifter
  import spi_hsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       abort,
  input  logic       lead,
  input  logic       trail,
  input  logic       cpha,
  input  logic       din,
  output logic       dout,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0] tx, rx;
  logic [3:0] cnt;
  logic       samp, shft;

  assign samp    = cpha ? trail : lead;
  assign shft    = cpha ? lead : trail;
  assign done    = trail && last_edge(cpha, cnt);
  assign dout    = tx[7];
  assign rx_byte = cpha ? push_bit(rx, din) : rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx  <= '0;
      rx  <= '0;
      cnt <= '0;
    end else if (load) begin
      tx  <= load_byte;
      cnt <= '0;
    end else if (abort) begin
      cnt <= '0;
    end else begin
      if (samp) begin
        rx  <= push_bit(rx, din);
        cnt <= cnt + 1'b1;
      end
      if (shft && !(cpha && cnt == 4'd0)) tx <= {tx[6:0], 1'b0};
      if (done) cnt <= '0;
    end
  end
endmodule

// File: rtl/spi_hsk.sv
module spi_hsk
  import spi_hsk_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_mask,
  output logic       irq,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       ss_n_i
);
  ctrl_t      ctrl;
  logic       load, flag, armed, m_busy, m_lead, m_trail, m_phase;
  logic       master_on, slave_on, s_lead, s_trail, lvl, lvl_d;
  logic       lead, trail, din, dout, xfer_done, data_wr_raw;
  logic [7:0] rx_byte;
  logic       sck_m, sck_s, sck_d, mosi_m, mosi_s, ss_m, ss_s;

  assign master_on   = ctrl.en && ctrl.master;
  assign slave_on    = ctrl.en && !ctrl.master;
  assign data_wr_raw = wr_en && (addr == OFS_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sck_m, sck_s, sck_d}  <= '0;
      {mosi_m, mosi_s}       <= '0;
      {ss_m, ss_s}           <= 2'b11;
    end else begin
      {sck_m, sck_s, sck_d} <= {sck_i, sck_m, sck_s};
      {mosi_m, mosi_s}      <= {mosi_i, mosi_m};
      {ss_m, ss_s}          <= {ss_n_i, ss_m};
    end
  end

  assign lvl     = sck_s ^ ctrl.cpol;
  assign lvl_d   = sck_d ^ ctrl.cpol;
  assign s_lead  = slave_on && !ss_s && lvl && !lvl_d;
  assign s_trail = slave_on && !ss_s && !lvl && lvl_d;
  assign lead    = master_on ? m_lead  : s_lead;
  assign trail   = master_on ? m_trail : s_trail;
  assign din     = master_on ? miso_i  : mosi_s;

  spi_hsk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .xfer_done(xfer_done), .rx_byte(rx_byte), .busy(m_busy),
    .ctrl(ctrl), .rdata(rdata), .load(load), .flag(flag), .armed(armed)
  );

  spi_hsk_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(load && master_on), .busy(m_busy),
    .lead(m_lead), .trail(m_trail), .phase(m_phase)
  );

  spi_hsk_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(wdata),
    .abort(slave_on && ss_s), .lead(lead), .trail(trail), .cpha(ctrl.cpha),
    .din(din), .dout(dout), .done(xfer_done), .rx_byte(rx_byte)
  );

  assign sck_o  = master_on ? (ctrl.cpol ^ m_phase) : ctrl.cpol;
  assign mosi_o = master_on && dout;
  assign miso_o = slave_on && !ss_s && dout;
  assign irq    = flag && ctrl.ie && !irq_mask;
endmodule

// File: rtl/spi_hsk_chk.sv
module spi_hsk_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic flag,
  input logic armed,
  input logic load,
  input logic wr_data,
  input logic busy,
  input logic master_on,
  input logic cpol,
  input logic sck_o,
  input logic ss_s
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load));
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(done));
  assert_clear_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed));
  assert_write_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && flag && !armed && master_on && !busy) |=> !busy);
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_on && !busy) |-> (sck_o == cpol));
  assert_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !master_on) |-> !ss_s);
endmodule

bind spi_hsk spi_hsk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(xfer_done), .flag(flag), .armed(armed),
  .load(load), .wr_data(data_wr_raw), .busy(m_busy), .master_on(master_on),
  .cpol(ctrl.cpol), .sck_o(sck_o), .ss_s(ss_s)
);

// File: tb/sim_spi_hsk.sv
module sim_spi_hsk;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int HS   = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq_mask = 0;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire  irq, sck_o, mosi_o, miso_o, miso_i;
  assign miso_i = ~mosi_o;

  int nchk = 0, nfail = 0;
  logic [7:0] exp_q[$];
  logic cpol_b = 0, cpha_b = 0, mon_on = 0, sck_prev = 0, lead_b;
  int cyc = 0, ecnt = 0, tot_edges = 0;
  logic [7:0] bits = 0, e;

  spi_hsk #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_mask(irq_mask), .irq(irq),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
    .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: rebuilds each master byte from mosi_o and pops the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (mon_on && sck_o != sck_prev) begin
      lead_b = (sck_o != cpol_b);
      if (ecnt != 0) check(cyc == HALF, "R6 half period", cyc, HALF);
      cyc = 0; ecnt++; tot_edges++;
      if (lead_b != cpha_b) bits = {bits[6:0], mosi_o};   // R7 sample edge
      if (ecnt == 16) begin
        ecnt = 0;
        check(exp_q.size() > 0, "R1 unexpected byte", bits, 0);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(bits == e, "R1/R7 mosi byte", bits, e);
        end
      end
    end
    sck_prev = sck_o;
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic master_mode(input logic [7:0] c);
    mon_on = 0;
    reg_wr(0, c);
    cpol_b = c[2]; cpha_b = c[3];
    repeat (2) @(negedge clk);
    check(sck_o == c[2], "R6 idle level", sck_o, c[2]);
    ecnt = 0; mon_on = 1;
  endtask

  task automatic master_byte(input logic [7:0] b);
    logic [7:0] r;
    exp_q.push_back(b);
    reg_wr(2, b);
    repeat (16 * HALF + 4) @(negedge clk);
    check(exp_q.size() == 0, "R1 byte sent", exp_q.size(), 0);
    check(irq == 1, "R2/R3 irq after done", irq, 1);
    reg_rd(1, r); check(r == 8'h80, "R2 status flag", r, 8'h80);
    reg_rd(2, r); check(r == ~b, "R8 received byte", r, ~b);
    check(irq == 0, "R4 cleared by status+read", irq, 0);
  endtask

  task automatic slv_byte(input logic [7:0] m, input int nb, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < nb; i++) begin
      if (!cpha_b) begin
        mosi_i = m[7 - i];
        repeat (HS) @(negedge clk);
        got = {got[6:0], miso_o}; sck_i = ~cpol_b;
        repeat (HS) @(negedge clk);
        sck_i = cpol_b;
      end else begin
        sck_i = ~cpol_b; mosi_i = m[7 - i];
        repeat (HS) @(negedge clk);
        got = {got[6:0], miso_o}; sck_i = cpol_b;
        repeat (HS) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] r, g;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    reg_rd(0, r); check(r == 0, "R11 ctrl reset", r, 0);
    reg_rd(1, r); check(r == 0, "R2 status reset", r, 0);
    check(irq == 0, "R3 irq reset", irq, 0);
    check(sck_o == 0, "R6 sck reset", sck_o, 0);

    // master, polarity 0 phase 0
    master_mode(8'h13);
    reg_rd(0, r); check(r == 8'h13, "R11 ctrl readback", r, 8'h13);
    exp_q.push_back(8'hA5);
    reg_wr(2, 8'hA5);
    repeat (16 * HALF + 4) @(negedge clk);
    check(irq == 1, "R2/R3 irq set", irq, 1);
    irq_mask = 1; #1 check(irq == 0, "R3 masked", irq, 0);
    irq_mask = 0;
    t = tot_edges;
    reg_wr(2, 8'h3C);                                  // R5: locked out
    repeat (20) @(negedge clk);
    check(tot_edges == t, "R5 write ignored no clock", tot_edges, t);
    check(irq == 1, "R5 flag kept", irq, 1);
    reg_rd(2, r); check(r == 8'h5A, "R8 rx is inverse", r, 8'h5A);
    check(irq == 1, "R4 read without status keeps flag", irq, 1);
    reg_rd(1, r); check(r == 8'h80, "R2 status bit7", r, 8'h80);
    reg_rd(2, r); check(irq == 0, "R4 status then read clears", irq, 0);

    // polarity 1 phase 1, clear through a data write that starts the next byte
    master_mode(8'h1F);
    exp_q.push_back(8'h81);
    reg_wr(2, 8'h81);
    repeat (16 * HALF + 4) @(negedge clk);
    reg_rd(1, r);
    exp_q.push_back(8'h7E);
    reg_wr(2, 8'h7E);
    check(irq == 0, "R4 master write clears", irq, 0);
    repeat (16 * HALF + 4) @(negedge clk);
    check(exp_q.size() == 0, "R1 second byte sent", exp_q.size(), 0);
    check(irq == 1, "R2 flag again", irq, 1);
    reg_rd(1, r);
    reg_rd(2, r); check(r == 8'h81, "R8 rx 7E inverted", r, 8'h81);

    master_mode(8'h1B); master_byte(8'h3C);           // R7 phase 1, pol 0
    master_mode(8'h17); master_byte(8'hC3);           // R7 phase 0, pol 1
    mon_on = 0;

    // slave, polarity 0 phase 0
    reg_wr(0, 8'h11); cpol_b = 0; cpha_b = 0; sck_i = 0;
    reg_wr(2, 8'h96);
    ss_n_i = 0;
    slv_byte(8'h4B, 8, g);
    ss_n_i = 1; repeat (4) @(negedge clk);
    check(g == 8'h96, "R1 slave miso byte", g, 8'h96);
    check(irq == 1, "R9 slave done", irq, 1);
    reg_rd(1, r);
    reg_wr(2, 8'h00);
    check(irq == 1, "R4 slave write does not clear", irq, 1);
    reg_rd(2, r); check(r == 8'h4B, "R9 slave rx", r, 8'h4B);
    check(irq == 0, "R4 slave read clears", irq, 0);

    // abort mid-byte
    ss_n_i = 0;
    slv_byte(8'hFF, 4, g);
    ss_n_i = 1; repeat (20) @(negedge clk);
    check(irq == 0, "R10 abort no flag", irq, 0);
    reg_rd(1, r); check(r == 0, "R10 abort status", r, 0);
    reg_wr(2, 8'h5A);
    ss_n_i = 0;
    slv_byte(8'hE1, 8, g);
    ss_n_i = 1; repeat (4) @(negedge clk);
    check(g == 8'h5A, "R10 full byte after abort", g, 8'h5A);
    reg_rd(1, r); check(r == 8'h80, "R10 flag after full byte", r, 8'h80);
    reg_rd(2, r); check(r == 8'hE1, "R10 rx after abort", r, 8'hE1);

    // slave, polarity 1 phase 1, select held low over two bytes
    reg_wr(0, 8'h1D); cpol_b = 1; cpha_b = 1; sck_i = 1;
    repeat (4) @(negedge clk);
    reg_wr(2, 8'hC6);
    ss_n_i = 0;
    slv_byte(8'h39, 8, g);
    check(g == 8'hC6, "R7 slave phase1 miso", g, 8'hC6);
    check(irq == 1, "R9 first held byte", irq, 1);
    reg_rd(1, r);
    reg_rd(2, r); check(r == 8'h39, "R9 rx held 1", r, 8'h39);
    reg_wr(2, 8'h0F);
    slv_byte(8'hF0, 8, g);
    check(g == 8'h0F, "R9 second held miso", g, 8'h0F);
    reg_rd(1, r);
    reg_rd(2, r); check(r == 8'hF0, "R9 rx held 2", r, 8'hF0);
    ss_n_i = 1;
    repeat (4) @(negedge clk);

    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule